// File: doc/BRIEF.md
# Cell Command-Byte Framer

This block is the transmit framer of a 25.6 Mbps cell PHY. Upstream logic writes cell bytes into it one per clock. Once a whole 53-byte cell sits in its three-cell buffer, the framer emits a nibble stream toward the scrambler and the 4b/5b encoder, one nibble per clock. Every nibble carries a tag: data, escape or command. Each cell is opened by a two-nibble command byte. That byte is either escape-escape, which also pulses a reset request to the scrambler's pseudo-random generator, or escape followed by code 4, which leaves the generator running.

A rising edge on the 8 kHz sync input is held as a pending request. The request is served at the next byte boundary by an escape followed by code 8, the timing marker. The marker can arrive in the middle of a cell. In that case the cell stops between two bytes and continues right after the marker. This is the only gap ever placed inside a cell.

The framer counts every nibble it emits, saturating at the generator's period of 1023 states. After the first cell, a cell start uses the resetting command only once that count has run full. When no cell is complete and no marker is pending, the output-valid signal stays low.

Top module: `cellCmdFramer`

## Requirements
- R1: While reset is held, outValid and prngReset are 0 and wrReady is 1.
- R2: A cell is not sent until all 53 of its bytes are buffered. With only part of a cell stored and no marker pending, outValid stays 0.
- R3: Each cell starts with an escape nibble (outTag 1, outNibble 0), then one of two things. Either a second escape nibble with prngReset high, or a command nibble (outTag 2) of value 4. No data nibble ever directly follows an escape that opens a command.
- R4: The bytes of a cell come out as 106 data nibbles (outTag 0), high nibble first, in write order. outValid stays high from the command byte through the last nibble, and tag value 3 never appears.
- R5: The first cell after reset uses the escape-escape command, with prngReset high on exactly that second escape nibble.
- R6: Each later cell uses escape-escape only when at least 1023 nibbles have been emitted since the last nibble that carried prngReset. Otherwise it uses escape-4.
- R7: A sync rising edge produces escape followed by a command nibble of value 8. Its second nibble appears no more than four clocks after the edge is sampled. It is placed only between bytes, never between the two nibbles of a byte and never inside another command byte. The interrupted cell then resumes.
- R8: Each rising edge of the sync input yields exactly one marker, however long the input stays high. This holds whether the line is idle or carrying a cell.
- R9: The buffer holds 159 bytes (three cells). wrReady is low exactly when 159 bytes are held, and a write offered while it is low is dropped.
- R10: When a sync edge and the completion of a cell reach an idle framer on the same clock, the marker goes out before that cell's command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Cell byte write strobe |
| wrData | input | 8 | Cell byte |
| wrReady | output | 1 | Buffer can take a byte this cycle |
| syncPulse | input | 1 | 8 kHz sync; a rising edge requests a timing marker |
| outValid | output | 1 | A nibble is presented this cycle |
| outNibble | output | 4 | Nibble value (0 for escape nibbles) |
| outTag | output | 2 | 0 data, 1 escape, 2 command code |
| prngReset | output | 1 | Scrambler generator reset, high on the second escape of escape-escape |

## Verification
The bench drives sync pulses at many phases within a streamed run of cells. A framer that split a byte would show a marker escape between a high and a low nibble. One that lost or doubled a request would show a marker count that does not match the pulses sent. At every cell start, the bench's own saturating nibble count is compared with the command chosen, so an off-by-one period check, or a counter that misses command nibbles, shows up as the wrong command. The stream fills the buffer while junk bytes are offered against a low wrReady. A framer that accepted them would corrupt the byte sequence, and a wrong full threshold would break the occupancy comparison. A marker that coincides with a cell completing catches a framer that lets the cell start win.

// File: rtl/framerPkg.sv
package framerPkg;

  typedef enum logic [1:0] {
    TAG_DATA = 2'd0,
    TAG_ESC  = 2'd1,
    TAG_CMD  = 2'd2
  } nibTag_e;

  localparam logic [3:0] CODE_NOWRAP = 4'h4;
  localparam logic [3:0] CODE_MARKER = 4'h8;
  localparam logic [3:0] ESC_FILL    = 4'h0;

  // strobes from control to datapath, one decision per clock
  typedef struct packed {
    logic       emitEsc;
    logic       emitCmd;
    logic [3:0] cmdCode;
    logic       emitData;
    logic       dataLow;
    logic       popByte;
    logic       prngReset;
  } framerStrobe_t;

endpackage

// File: rtl/framerDatapath.sv
module framerDatapath
  import framerPkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int FIFO_CELLS = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [7:0]    wrData,
  output logic          wrReady,
  input  framerStrobe_t stb,
  output logic          cellReady,
  output logic          lastByte,
  output logic          outValid,
  output logic [3:0]    outNibble,
  output logic [1:0]    outTag,
  output logic          prngReset
);

  localparam int DEPTH   = CELL_BYTES * FIFO_CELLS;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int OCC_W   = $clog2(DEPTH + 1);
  localparam int IDX_W   = $clog2(CELL_BYTES);
  localparam int CELLS_W = $clog2(FIFO_CELLS + 1);

  logic [7:0]         mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [OCC_W-1:0]   occupancy;
  logic [IDX_W-1:0]   wrIdx, rdIdx;
  logic [CELLS_W-1:0] completeCells;
  logic               wrAccept, cellIn, cellOut;
  logic [7:0]         rdByte;

  assign wrReady   = (occupancy != OCC_W'(DEPTH));
  assign wrAccept  = wrEn && wrReady;
  assign cellIn    = wrAccept && (wrIdx == IDX_W'(CELL_BYTES - 1));
  assign lastByte  = (rdIdx == IDX_W'(CELL_BYTES - 1));
  assign cellOut   = stb.popByte && lastByte;
  assign cellReady = (completeCells != '0);
  assign rdByte    = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrAccept) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      wrIdx <= '0;
    end else if (wrAccept) begin
      wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      wrIdx <= (wrIdx == IDX_W'(CELL_BYTES - 1)) ? '0 : wrIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      rdIdx <= '0;
    end else if (stb.popByte) begin
      rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      rdIdx <= lastByte ? '0 : rdIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occupancy <= '0;
    end else begin
      case ({wrAccept, stb.popByte})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      completeCells <= '0;
    end else begin
      case ({cellIn, cellOut})
        2'b10:   completeCells <= completeCells + 1'b1;
        2'b01:   completeCells <= completeCells - 1'b1;
        default: completeCells <= completeCells;
      endcase
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outNibble <= '0;
      outTag    <= TAG_DATA;
      prngReset <= 1'b0;
    end else begin
      outValid  <= stb.emitEsc || stb.emitCmd || stb.emitData;
      prngReset <= stb.prngReset;
      if (stb.emitData) begin
        outNibble <= stb.dataLow ? rdByte[3:0] : rdByte[7:4];
        outTag    <= TAG_DATA;
      end else if (stb.emitCmd) begin
        outNibble <= stb.cmdCode;
        outTag    <= TAG_CMD;
      end else begin
        outNibble <= ESC_FILL;
        outTag    <= TAG_ESC;
      end
    end
  end

endmodule

// File: rtl/framerControl.sv
module framerControl
  import framerPkg::*;
#(
  parameter int PRNG_PERIOD = 1023
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncPulse,
  input  logic          cellReady,
  input  logic          lastByte,
  output framerStrobe_t stb
);

  localparam int CNT_W = $clog2(PRNG_PERIOD + 1);

  typedef enum logic [1:0] {S_IDLE, S_CMD2, S_HI, S_LO} ctrlState_e;

  ctrlState_e       state, nextState;
  logic             isMarker, resumeHi, firstCell;
  logic             syncPrev, markPend, syncRise, takeMark;
  logic [CNT_W-1:0] nibCnt;
  logic             resetDue, anyEmit;

  assign syncRise = syncPulse && !syncPrev;
  assign resetDue = firstCell || (nibCnt == CNT_W'(PRNG_PERIOD));
  assign anyEmit  = stb.emitEsc || stb.emitCmd || stb.emitData;

  always_comb begin
    stb       = '0;
    nextState = state;
    takeMark  = 1'b0;
    case (state)
      S_IDLE: begin
        if (markPend) begin
          stb.emitEsc = 1'b1;
          takeMark    = 1'b1;
          nextState   = S_CMD2;
        end else if (cellReady) begin
          stb.emitEsc = 1'b1;
          nextState   = S_CMD2;
        end
      end
      S_CMD2: begin
        if (isMarker) begin
          stb.emitCmd = 1'b1;
          stb.cmdCode = CODE_MARKER;
          nextState   = resumeHi ? S_HI : S_IDLE;
        end else begin
          nextState = S_HI;
          if (resetDue) begin
            stb.emitEsc   = 1'b1;
            stb.prngReset = 1'b1;
          end else begin
            stb.emitCmd = 1'b1;
            stb.cmdCode = CODE_NOWRAP;
          end
        end
      end
      S_HI: begin
        if (markPend) begin
          stb.emitEsc = 1'b1;
          takeMark    = 1'b1;
          nextState   = S_CMD2;
        end else begin
          stb.emitData = 1'b1;
          nextState    = S_LO;
        end
      end
      default: begin
        stb.emitData = 1'b1;
        stb.dataLow  = 1'b1;
        stb.popByte  = 1'b1;
        nextState    = lastByte ? S_IDLE : S_HI;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      isMarker <= 1'b0;
      resumeHi <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.emitEsc && (state != S_CMD2)) begin
        isMarker <= takeMark;
        resumeHi <= (state == S_HI);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      markPend <= 1'b0;
    end else begin
      syncPrev <= syncPulse;
      markPend <= syncRise || (markPend && !takeMark);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nibCnt    <= '0;
      firstCell <= 1'b1;
    end else if (stb.prngReset) begin
      nibCnt    <= '0;
      firstCell <= 1'b0;
    end else if (anyEmit && (nibCnt != CNT_W'(PRNG_PERIOD))) begin
      nibCnt <= nibCnt + 1'b1;
    end
  end

endmodule

// File: rtl/cellCmdFramer.sv
module cellCmdFramer
  import framerPkg::*;
#(
  parameter int CELL_BYTES  = 53,
  parameter int FIFO_CELLS  = 3,
  parameter int PRNG_PERIOD = 1023
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic       wrReady,
  input  logic       syncPulse,
  output logic       outValid,
  output logic [3:0] outNibble,
  output logic [1:0] outTag,
  output logic       prngReset
);

  framerStrobe_t stb;
  logic          cellReady, lastByte;

  framerControl #(.PRNG_PERIOD(PRNG_PERIOD)) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .syncPulse (syncPulse),
    .cellReady (cellReady),
    .lastByte  (lastByte),
    .stb       (stb)
  );

  framerDatapath #(.CELL_BYTES(CELL_BYTES), .FIFO_CELLS(FIFO_CELLS)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .wrReady   (wrReady),
    .stb       (stb),
    .cellReady (cellReady),
    .lastByte  (lastByte),
    .outValid  (outValid),
    .outNibble (outNibble),
    .outTag    (outTag),
    .prngReset (prngReset)
  );

endmodule

// File: rtl/framerChk.sv
module framerChk
  import framerPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       outValid,
  input logic [3:0] outNibble,
  input logic [1:0] outTag,
  input logic       prngReset
);

  // R3
  esc_no_data_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag == TAG_ESC && !prngReset) |=> (outValid && outTag != TAG_DATA));

  // R3
  cmd_code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag == TAG_CMD) |-> (outNibble == CODE_NOWRAP || outNibble == CODE_MARKER));

  // R3
  cmd_after_esc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag == TAG_CMD) |-> $past(outValid && outTag == TAG_ESC && !prngReset));

  // R5
  reset_on_second_esc_chk: assert property (@(posedge clk) disable iff (!rstN)
    prngReset |-> (outValid && outTag == TAG_ESC && $past(outValid && outTag == TAG_ESC && !prngReset)));

  // R4
  tag_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outTag != 2'd3));

endmodule

bind cellCmdFramer framerChk i_framerChk (
  .clk       (clk),
  .rstN      (rstN),
  .outValid  (outValid),
  .outNibble (outNibble),
  .outTag    (outTag),
  .prngReset (prngReset)
);

// File: tb/test_cellCmdFramer.sv
`timescale 1ns/1ps
module test_cellCmdFramer;

  localparam int CELL  = 53;
  localparam int CAP   = 159;
  localparam int PER   = 1023;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       wrReady;
  logic       syncPulse = 1'b0;
  logic       outValid;
  logic [3:0] outNibble;
  logic [1:0] outTag;
  logic       prngReset;

  always #2.5 clk = ~clk;

  cellCmdFramer i_cellCmdFramer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrReady(wrReady),
    .syncPulse(syncPulse), .outValid(outValid), .outNibble(outNibble),
    .outTag(outTag), .prngReset(prngReset)
  );

  int checks = 0, failures = 0, cycles = 0;
  // monitor state
  int cnt = 0, first = 1, expSecond = 0, inCell = 0, nibIn = 0, cellBytes = 0;
  int bytesOut = 0, markers = 0, laterResets = 0, esc4s = 0, fullSeen = 0, anyValid = 0;
  int pulseAge = 100, expectMarkerFirst = 0;
  logic [3:0] hiNib = 4'h0;
  // stimulus state
  int written = 0, wrTarget = 0, syncWithNext = 0;
  int pulseReqs = 0, pulsesStarted = 0, pulseLen = 1, pulseLeft = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 73 + 19) ^ (i >> 3));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      failures++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (pulseAge < 100) pulseAge++;
    if (rstN) begin
      // ---- monitor ----
      if (outValid) begin
        anyValid = 1;
        if (expSecond) begin
          expSecond = 0;
          if (outTag == 2'd1) begin
            check(prngReset, "R5 reset on second escape", prngReset, 1);
            check(first || cnt == PER, "R6 reset start only when due", cnt, PER);
            check(!expectMarkerFirst, "R10 marker before cell", 0, 8);
            if (!first) laterResets++;
            first = 0; inCell = 1; cellBytes = 0;
          end else if (outTag == 2'd2 && outNibble == 4'h4) begin
            check(!(first || cnt == PER), "R6 escape-4 only when not due", cnt, PER);
            check(!expectMarkerFirst, "R10 marker before cell", 4, 8);
            esc4s++; inCell = 1; cellBytes = 0;
          end else if (outTag == 2'd2 && outNibble == 4'h8) begin
            markers++;
            check(pulseAge <= 4, "R7 marker latency", pulseAge, 4);
            expectMarkerFirst = 0;
          end else begin
            check(0, "R3 second nibble of command", outNibble, 4);
          end
        end else if (outTag == 2'd1) begin
          check(!prngReset, "R3 first escape has no reset", prngReset, 0);
          check(nibIn == 0, "R7 no split byte", nibIn, 0);
          expSecond = 1;
        end else if (outTag == 2'd0) begin
          check(inCell != 0, "R4 data only inside cell", inCell, 1);
          if (nibIn == 0) begin
            hiNib = outNibble; nibIn = 1;
          end else begin
            check({hiNib, outNibble} == pat(bytesOut), "R4 byte order",
                  {hiNib, outNibble}, pat(bytesOut));
            bytesOut++; cellBytes++; nibIn = 0;
            if (cellBytes == CELL) inCell = 0;
          end
        end else begin
          check(0, "R4 legal tag", outTag, 0);
        end
        if (prngReset) cnt = 0;
        else if (cnt < PER) cnt++;
      end else begin
        check(!inCell && !expSecond, "R4 contiguous cell", inCell, 0);
        check(!prngReset, "R3 reset only with valid", prngReset, 0);
      end
      // ---- occupancy ----
      check(wrReady == ((written - bytesOut) < CAP), "R9 wrReady vs occupancy",
            wrReady, (written - bytesOut) < CAP);
      if (!wrReady) fullSeen = 1;
      // ---- sync driver ----
      if (pulseLeft > 0) begin
        syncPulse = 1'b1; pulseLeft--;
      end else if (pulseReqs > pulsesStarted) begin
        pulsesStarted++; pulseLeft = pulseLen - 1; syncPulse = 1'b1; pulseAge = 0;
      end else begin
        syncPulse = 1'b0;
      end
      // ---- feeder ----
      if (written < wrTarget) begin
        wrEn = 1'b1;
        if (wrReady) begin
          wrData = pat(written);
          written++;
          if (syncWithNext != 0 && written == wrTarget) begin
            syncWithNext = 0; pulsesStarted++; pulseReqs++;
            pulseLeft = 0; syncPulse = 1'b1; pulseAge = 0;
          end
        end else begin
          wrData = 8'hEE;
        end
      end else begin
        wrEn = 1'b0;
      end
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic waitBytes(int n);
    while (bytesOut < n) @(posedge clk);
  endtask

  task automatic pulse(int len);
    pulseLen = len;
    pulseReqs++;
  endtask

  initial begin
    waitCycles(4);
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    check(prngReset == 1'b0, "R1 prngReset in reset", prngReset, 0);
    check(wrReady == 1'b1, "R1 wrReady in reset", wrReady, 1);
    rstN = 1'b1;
    @(posedge clk);
    // partial cell stays silent
    wrTarget = 52;
    waitCycles(60);
    check(anyValid == 0, "R2 no output before full cell", anyValid, 0);
    // complete it: first cell must be escape-escape
    wrTarget = 53;
    waitBytes(53);
    waitCycles(4);
    check(first == 0 && laterResets == 0, "R5 first cell reset command", first, 0);
    // second cell completes on the same clock as a sync edge
    wrTarget = 105;
    waitCycles(80);
    check(bytesOut == 53, "R2 partial second cell held", bytesOut, 53);
    expectMarkerFirst = 1;
    syncWithNext = 1;
    wrTarget = 106;
    waitBytes(106);
    check(markers == 1, "R10 marker count", markers, 1);
    check(expectMarkerFirst == 0, "R10 marker seen", expectMarkerFirst, 0);
    // streamed cells with markers at many phases
    wrTarget = 106 + CELL * 24;
    for (int i = 0; i < 8; i++) begin
      waitCycles(41 + i * 17);
      pulse((i % 3) + 1);
    end
    waitCycles(60);
    pulse(6);
    waitBytes(wrTarget);
    waitCycles(10);
    check(markers == 10, "R8 one marker per edge in stream", markers, 10);
    // marker on an idle line
    pulse(2);
    waitCycles(12);
    check(markers == 11, "R8 idle marker", markers, 11);
    check(laterResets >= 1, "R6 periodic reset start seen", laterResets, 1);
    check(esc4s >= 1, "R6 non-reset start seen", esc4s, 1);
    check(fullSeen == 1, "R9 buffer reached full", fullSeen, 1);
    check(inCell == 0 && expSecond == 0, "R4 stream ended cleanly", inCell, 0);
    summary();
    $finish;
  end

endmodule